// File: doc/BRIEF.md
# Atomic-aware memory command encoder

This block sits between a load/store unit and a cache port. Each cycle it may be handed one request, a read or a write, together with attribute flags for load-linked/store-conditional, swap and compare-and-swap. It turns the request into the command code placed on the port. A plain read becomes a load-locked command when it carries the linked attribute. A write becomes a swap command, a store-conditional command or a plain write. A compare-and-swap write carries its compare value as extra data beside the store data.

A store-conditional whose reservation check has failed never reaches the port. It is finished locally and reported as complete with a failed result. The block also tracks the port's flow control. A refused issue sets a blocked flag and asks the requester to try again. A retry pulse from the port clears the flag. An accepted issue leaves a single access outstanding until the port answers.

Top module: `mem_cmd_encoder`

## Requirements
- R1: After reset, port_blocked, acc_pending, req_done, req_nack and sc_ok are all 0.
- R2: A read (req_write=0) is encoded as READ (port_cmd=0), or as LOAD_LOCKED (port_cmd=2) when req_linked=1. A read never drives extra data.
- R3: A write with req_swap=1 is encoded as SWAP (port_cmd=4). Swap takes priority over req_linked.
- R4: A write with req_linked=1 and req_swap=0 is encoded as STORE_COND (port_cmd=3).
- R5: Any other write is encoded as WRITE (port_cmd=1), and port_wdata equals req_wdata.
- R6: A write with req_cas=1 drives port_extra_en=1 and port_extra=req_cmp. In every other case port_extra_en=0.
- R7: A store-conditional presented with rsv_valid=0 does not raise port_issue. In the next cycle req_done=1 and sc_ok=0 and no access is pending. This also holds while the port is blocked.
- R8: When port_issue is high and port_ready is low, the next cycle shows port_blocked=1, req_nack=1 and acc_pending=0.
- R9: While port_blocked=1, a request does not raise port_issue and is answered with req_nack=1 in the next cycle. A port_retry pulse clears port_blocked in the next cycle.
- R10: When port_issue and port_ready are both high, the next cycle shows acc_pending=1 and port_blocked=0.
- R11: port_resp while an access is pending gives, in the next cycle, req_done=1 and acc_pending=0. At the same time sc_ok=1 if the issued request was a store-conditional, otherwise sc_ok=0.
- R12: A request presented while an access is pending does not raise port_issue and is answered with req_nack=1 in the next cycle. This includes a store-conditional that would fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_linked | input | 1 | Load-linked / store-conditional attribute |
| req_swap | input | 1 | Swap attribute |
| req_cas | input | 1 | Compare-and-swap attribute |
| req_wdata | input | DATA_W | Store data |
| req_cmp | input | DATA_W | Compare value for compare-and-swap |
| rsv_valid | input | 1 | Reservation check passed |
| port_ready | input | 1 | Port accepts an issue this cycle |
| port_retry | input | 1 | Port can take requests again |
| port_resp | input | 1 | Port answers the outstanding access |
| port_issue | output | 1 | Issue strobe to the port |
| port_cmd | output | 3 | Encoded command |
| port_wdata | output | DATA_W | Store data to the port |
| port_extra | output | DATA_W | Extra data (compare value) |
| port_extra_en | output | 1 | Extra data is attached |
| port_blocked | output | 1 | Port refused the last issue and has not sent a retry |
| acc_pending | output | 1 | An access is outstanding |
| req_done | output | 1 | Request completed (response or local store-conditional finish) |
| req_nack | output | 1 | Request not done; the requester must present it again |
| sc_ok | output | 1 | Store-conditional result, valid with req_done |

## Verification
The hardest case to reach is a failing store-conditional that meets a port that has just refused an issue. The bench first presents a write while port_ready is low, so the port becomes blocked. It then presents a store-conditional with the reservation cleared. It checks that this request finishes locally and is not nacked, while a plain request in the same blocked state is nacked. The bench also opens an outstanding access and then presents a failing store-conditional. This shows that the pending access takes precedence and the request is nacked rather than finished.

// File: rtl/mce_pkg.sv
// Package: command codes shared by the encoder modules.
// Assumes a 3-bit command field on the cache port.
package mce_pkg;
    localparam int CMD_W = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_READ        = 3'd0,
        CMD_WRITE       = 3'd1,
        CMD_LOAD_LOCKED = 3'd2,
        CMD_STORE_COND  = 3'd3,
        CMD_SWAP        = 3'd4
    } mem_cmd_t;
endpackage

// File: rtl/mce_classify.sv
// Module: mce_classify
// Combinational mapping of request type and attributes to a port command.
// It also marks store-conditionals and attaches compare data.
// Assumes attributes are only meaningful while a request is presented.
module mce_classify
    import mce_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              is_write,
    input  logic              attr_linked,
    input  logic              attr_swap,
    input  logic              attr_cas,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] cmp_in,
    output mem_cmd_t          cmd,
    output logic              is_sc,
    output logic [DATA_W-1:0] wdata_out,
    output logic [DATA_W-1:0] extra_out,
    output logic              extra_en
);

    // Select the command: swap over store-conditional over plain write.
    always_comb begin
        if (!is_write) begin
            cmd = attr_linked ? CMD_LOAD_LOCKED : CMD_READ;
        end else if (attr_swap) begin
            cmd = CMD_SWAP;
        end else if (attr_linked) begin
            cmd = CMD_STORE_COND;
        end else begin
            cmd = CMD_WRITE;
        end
    end

    // Flag store-conditionals and attach compare data to CAS writes.
    always_comb begin
        is_sc     = is_write && attr_linked && !attr_swap;
        extra_en  = is_write && attr_cas;
        extra_out = extra_en ? cmp_in : '0;
        wdata_out = wdata_in;
    end

endmodule

// File: rtl/mce_port_ctl.sv
// Module: mce_port_ctl
// Issue control for a single-outstanding cache port. It owns the blocked
// flag and the pending flag, and it raises done/nack pulses.
// Assumes the port answers each accepted access with one port_resp pulse.
module mce_port_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic is_sc,
    input  logic sc_fail,
    input  logic port_ready,
    input  logic port_retry,
    input  logic port_resp,
    output logic port_issue,
    output logic port_blocked,
    output logic acc_pending,
    output logic req_done,
    output logic req_nack,
    output logic sc_ok
);

    logic pend_is_sc;

    // Issue only when the slot is free, the port is open and the SC survives.
    always_comb begin
        port_issue = req_valid && !acc_pending && !port_blocked && !sc_fail;
    end

    // Track port state and emit one-cycle completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_blocked <= 1'b0;
            acc_pending  <= 1'b0;
            pend_is_sc   <= 1'b0;
            req_done     <= 1'b0;
            req_nack     <= 1'b0;
            sc_ok        <= 1'b0;
        end else begin
            req_done <= 1'b0;
            req_nack <= 1'b0;
            sc_ok    <= 1'b0;
            if (port_retry) begin
                port_blocked <= 1'b0;
            end
            if (port_resp && acc_pending) begin
                acc_pending <= 1'b0;
                req_done    <= 1'b1;
                sc_ok       <= pend_is_sc;
            end
            if (req_valid) begin
                if (acc_pending) begin
                    req_nack <= 1'b1;
                end else if (sc_fail) begin
                    req_done <= 1'b1;
                end else if (port_blocked) begin
                    req_nack <= 1'b1;
                end else if (port_ready) begin
                    acc_pending  <= 1'b1;
                    pend_is_sc   <= is_sc;
                    port_blocked <= 1'b0;
                end else begin
                    port_blocked <= 1'b1;
                    req_nack     <= 1'b1;
                end
            end
        end
    end

    // R8: a refused issue blocks the port and nacks the request.
    a_r8_refuse_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        port_issue && !port_ready |=> port_blocked && req_nack && !acc_pending);

    // R10: an accepted issue leaves an access pending with the port open.
    a_r10_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
        port_issue && port_ready |=> acc_pending && !port_blocked);

    // R9: nothing is issued while the port is blocked.
    a_r9_no_issue_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        port_blocked |-> !port_issue);

    // R12: a second request while pending is nacked.
    a_r12_pending_nack: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && acc_pending |=> req_nack);

    // R11: the result flag is only raised together with completion.
    a_r11_result_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        sc_ok |-> req_done);

endmodule

// File: rtl/mem_cmd_encoder.sv
// Module: mem_cmd_encoder
// Top level. Encodes read/write requests with atomic attributes into cache
// port commands, drops failing store-conditionals, and handles the port's
// blocked/retry handshake. Assumes one request at most per cycle.
module mem_cmd_encoder
    import mce_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_linked,
    input  logic              req_swap,
    input  logic              req_cas,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] req_cmp,
    input  logic              rsv_valid,
    input  logic              port_ready,
    input  logic              port_retry,
    input  logic              port_resp,
    output logic              port_issue,
    output logic [CMD_W-1:0]  port_cmd,
    output logic [DATA_W-1:0] port_wdata,
    output logic [DATA_W-1:0] port_extra,
    output logic              port_extra_en,
    output logic              port_blocked,
    output logic              acc_pending,
    output logic              req_done,
    output logic              req_nack,
    output logic              sc_ok
);

    mem_cmd_t cmd;
    logic     is_sc;
    logic     sc_fail;

    mce_classify #(.DATA_W(DATA_W)) u_classify (
        .is_write    (req_write),
        .attr_linked (req_linked),
        .attr_swap   (req_swap),
        .attr_cas    (req_cas),
        .wdata_in    (req_wdata),
        .cmp_in      (req_cmp),
        .cmd         (cmd),
        .is_sc       (is_sc),
        .wdata_out   (port_wdata),
        .extra_out   (port_extra),
        .extra_en    (port_extra_en)
    );

    // A store-conditional whose reservation is lost is finished locally.
    always_comb begin
        sc_fail  = is_sc && !rsv_valid;
        port_cmd = cmd;
    end

    mce_port_ctl u_port_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .is_sc        (is_sc),
        .sc_fail      (sc_fail),
        .port_ready   (port_ready),
        .port_retry   (port_retry),
        .port_resp    (port_resp),
        .port_issue   (port_issue),
        .port_blocked (port_blocked),
        .acc_pending  (acc_pending),
        .req_done     (req_done),
        .req_nack     (req_nack),
        .sc_ok        (sc_ok)
    );

    // R7: a failing store-conditional on a free slot completes, with no access.
    a_r7_sc_fail_local: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && is_sc && !rsv_valid && !acc_pending
        |=> req_done && !sc_ok && !acc_pending);

    // R7: a failing store-conditional never reaches the port.
    a_r7_sc_fail_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && is_sc && !rsv_valid |-> !port_issue);

    // R6: extra data is attached only to writes.
    a_r6_extra_writes_only: assert property (@(posedge clk) disable iff (!rst_n)
        port_extra_en |-> req_write);

endmodule

// File: tb/test_mem_cmd_encoder.sv
module test_mem_cmd_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, req_linked = 0, req_swap = 0, req_cas = 0;
    logic [DW-1:0] req_wdata = '0, req_cmp = '0;
    logic rsv_valid = 0, port_ready = 0, port_retry = 0, port_resp = 0;
    logic port_issue, port_extra_en, port_blocked, acc_pending, req_done, req_nack, sc_ok;
    logic [2:0] port_cmd;
    logic [DW-1:0] port_wdata, port_extra;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_cmd_encoder #(.DATA_W(DW)) i_mem_cmd_encoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_linked(req_linked), .req_swap(req_swap), .req_cas(req_cas),
        .req_wdata(req_wdata), .req_cmp(req_cmp), .rsv_valid(rsv_valid),
        .port_ready(port_ready), .port_retry(port_retry), .port_resp(port_resp),
        .port_issue(port_issue), .port_cmd(port_cmd), .port_wdata(port_wdata),
        .port_extra(port_extra), .port_extra_en(port_extra_en),
        .port_blocked(port_blocked), .acc_pending(acc_pending),
        .req_done(req_done), .req_nack(req_nack), .sc_ok(sc_ok)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present one request at a negedge; comb outputs are checked 1 time unit later.
    task automatic present(input logic w, input logic ll, input logic sw, input logic cas,
                           input logic [DW-1:0] wd, input logic [DW-1:0] cmp,
                           input logic rsv, input logic rdy);
        @(negedge clk);
        req_valid = 1; req_write = w; req_linked = ll; req_swap = sw; req_cas = cas;
        req_wdata = wd; req_cmp = cmp; rsv_valid = rsv; port_ready = rdy;
        #1;
    endtask

    // Step to the next negedge and drop the request.
    task automatic settle();
        @(negedge clk);
        req_valid = 0; req_write = 0; req_linked = 0; req_swap = 0; req_cas = 0;
        rsv_valid = 0; port_ready = 0;
        #1;
    endtask

    // Answer the pending access and check completion.
    task automatic respond(input logic exp_sc, input string tag);
        @(negedge clk);
        port_resp = 1;
        @(negedge clk);
        port_resp = 0;
        #1;
        check({tag, " done"}, req_done, 1);
        check({tag, " sc_ok"}, sc_ok, exp_sc);
        check({tag, " pending clear"}, acc_pending, 0);
    endtask

    task automatic t_reset();
        check("R1 blocked", port_blocked, 0);
        check("R1 pending", acc_pending, 0);
        check("R1 done", req_done, 0);
        check("R1 nack", req_nack, 0);
        check("R1 sc_ok", sc_ok, 0);
    endtask

    task automatic t_reads();
        present(0, 0, 0, 1, 0, 32'h55, 1, 1);
        check("R2 read cmd", port_cmd, 0);
        check("R2 read issue", port_issue, 1);
        check("R2 read no extra", port_extra_en, 0);
        settle();
        check("R10 pending", acc_pending, 1);
        check("R10 not blocked", port_blocked, 0);
        respond(0, "R11 read");
        present(0, 1, 0, 0, 0, 0, 1, 1);
        check("R2 load-locked cmd", port_cmd, 2);
        settle();
        respond(0, "R11 ll");
    endtask

    task automatic t_writes();
        present(1, 1, 1, 0, 32'h11, 0, 1, 1);
        check("R3 swap cmd", port_cmd, 4);
        settle();
        respond(0, "R11 swap");
        present(1, 1, 0, 0, 32'h22, 0, 1, 1);
        check("R4 sc cmd", port_cmd, 3);
        check("R4 sc issue", port_issue, 1);
        settle();
        respond(1, "R11 sc success");
        present(1, 0, 0, 0, 32'hCAFE0001, 0, 0, 1);
        check("R5 write cmd", port_cmd, 1);
        check("R5 wdata", port_wdata, 32'hCAFE0001);
        check("R6 plain no extra", port_extra_en, 0);
        settle();
        respond(0, "R11 write");
        present(1, 0, 0, 1, 32'h3, 32'hBEEF, 0, 1);
        check("R6 cas cmd", port_cmd, 1);
        check("R6 cas extra_en", port_extra_en, 1);
        check("R6 cas extra", port_extra, 32'hBEEF);
        settle();
        respond(0, "R11 cas");
    endtask

    task automatic t_sc_fail();
        present(1, 1, 0, 0, 32'h9, 0, 0, 1);
        check("R7 no issue", port_issue, 0);
        settle();
        check("R7 done", req_done, 1);
        check("R7 sc_ok", sc_ok, 0);
        check("R7 nothing pending", acc_pending, 0);
        check("R7 no nack", req_nack, 0);
    endtask

    task automatic t_blocked();
        present(1, 0, 0, 0, 32'h7, 0, 0, 0);
        check("R8 issue attempted", port_issue, 1);
        settle();
        check("R8 blocked", port_blocked, 1);
        check("R8 nack", req_nack, 1);
        check("R8 not pending", acc_pending, 0);
        present(0, 0, 0, 0, 0, 0, 0, 1);
        check("R9 no issue while blocked", port_issue, 0);
        settle();
        check("R9 nack while blocked", req_nack, 1);
        check("R9 still blocked", port_blocked, 1);
        present(1, 1, 0, 0, 0, 0, 0, 1);
        settle();
        check("R7 sc fail done while blocked", req_done, 1);
        check("R7 sc fail no nack while blocked", req_nack, 0);
        @(negedge clk);
        port_retry = 1;
        @(negedge clk);
        port_retry = 0;
        #1;
        check("R9 retry clears", port_blocked, 0);
        present(1, 0, 0, 0, 32'h7, 0, 0, 1);
        check("R10 reissue", port_issue, 1);
        settle();
        check("R10 pending after retry", acc_pending, 1);
    endtask

    task automatic t_pending();
        present(0, 0, 0, 0, 0, 0, 1, 1);
        check("R12 no issue while pending", port_issue, 0);
        settle();
        check("R12 nack", req_nack, 1);
        check("R12 still pending", acc_pending, 1);
        present(1, 1, 0, 0, 0, 0, 0, 1);
        settle();
        check("R12 sc fail nacked", req_nack, 1);
        check("R12 sc fail not done", req_done, 0);
        respond(0, "R11 after pending");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        t_reset();
        t_reads();
        t_writes();
        t_sc_fail();
        t_blocked();
        t_pending();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule